// File: doc/BRIEF.md
# Sequenced Enable Clock-Domain Crossing

This block moves a single load-enable from a source clock domain into an unrelated destination clock domain. In the destination domain it drives a two-register pipeline. The first register captures the source data bus while the synchronized enable is high. The second register then copies the first register while a follow-on enable is high. The source holds the data bus stable for as long as its enable is asserted, so the bus itself needs no synchronizer.

Only the first enable crosses the boundary. The follow-on enable is rebuilt on the destination side by delaying the synchronized enable through one flip-flop. Because both enables come from the same synchronizer output and share the destination clock, the offset between them is always exactly one destination cycle. No destination cycle can therefore see both enables low at the hand-over, and the pipeline never loses a step.

Top module: `enable_chain_cdc`

## Requirements
- R1: With the destination reset (active high, synchronous) asserted at a destination edge, both enables and both data registers read zero after that edge.
- R2: After the source enable rises, the first-stage enable rises no earlier than SYNC_STAGES destination edges after the source-side enable register has captured it, and no later than SYNC_STAGES plus the source period rounded up in destination cycles plus two destination cycles.
- R3: The second-stage enable in any destination cycle equals the first-stage enable of the previous destination cycle.
- R4: In a cycle where the first-stage enable has just fallen, the second-stage enable is high, so there is never a cycle with both low between them.
- R5: The first-stage register loads the source data bus at each destination edge where the first-stage enable is high, and otherwise holds its value.
- R6: The second-stage register loads the first-stage register at each destination edge where the second-stage enable is high, and otherwise holds its value.
- R7: Each source enable pulse held for at least two destination periods produces exactly one contiguous high run of the first-stage enable.
- R8: Asserting the source reset (active high, synchronous) clears the source enable register, so the first-stage enable falls within the R2 latency bound and stays low while the source reset is held, even with the source enable input high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source domain clock |
| srcRst | input | 1 | Source domain synchronous reset, active high |
| srcEn | input | 1 | Source load-enable request |
| srcData | input | DATA_W | Source data bus, stable while srcEn is high |
| dstClk | input | 1 | Destination domain clock |
| dstRst | input | 1 | Destination domain synchronous reset, active high |
| stage1En | output | 1 | Synchronized first-stage enable |
| stage2En | output | 1 | Locally derived second-stage enable |
| stage1Data | output | DATA_W | First-stage register value |
| stage2Data | output | DATA_W | Second-stage register value |

## Verification
The two events that fall in the same destination cycle are the first stage letting go of its enable and the second stage taking over. The second register also captures the first register on the same edge that the first register may be reloading. The bench provokes these events with source clocks that are faster than, slower than, and drifting against the destination clock, plus idle gaps of varying length, so that the enable edge lands at many phases. A behavioural model checks on every destination cycle that the second enable copies the previous first enable, that no both-low gap follows a fall, and that the second register holds the value the first register held one cycle earlier.

// File: rtl/enable_chain_pkg.sv
package enable_chain_pkg;

  // Load strobes handed from destination control to the datapath
  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
  } stageStrobes_t;

endpackage

// File: rtl/enable_chain_src.sv
module enable_chain_src (
  input  logic srcClk,
  input  logic srcRst,
  input  logic srcEn,
  output logic srcEnQ
);

  // Launch flop: the crossing is fed only from a register, never from logic
  always_ff @(posedge srcClk) begin
    if (srcRst) srcEnQ <= 1'b0;
    else        srcEnQ <= srcEn;
  end

endmodule

// File: rtl/enable_chain_ctrl.sv
module enable_chain_ctrl
  import enable_chain_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          dstClk,
  input  logic          dstRst,
  input  logic          srcEnQ,
  output stageStrobes_t strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   firstEn;
  logic                   secondEn;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge dstClk) begin
        if (dstRst) syncChain <= '0;
        else        syncChain <= srcEnQ;
      end
    end else begin : g_chain
      always_ff @(posedge dstClk) begin
        if (dstRst) syncChain <= '0;
        else        syncChain <= {syncChain[SYNC_STAGES-2:0], srcEnQ};
      end
    end
  endgenerate

  assign firstEn = syncChain[LAST];

  // Second enable rebuilt locally: one flop behind the synchronized enable
  always_ff @(posedge dstClk) begin
    if (dstRst) secondEn <= 1'b0;
    else        secondEn <= firstEn;
  end

  assign strobes.loadFirst  = firstEn;
  assign strobes.loadSecond = secondEn;

  // R7: a synchronized run of the first enable never falls back the cycle it rose
  first_run_chk: assert property (@(posedge dstClk) disable iff (dstRst)
    (!$past(dstRst) && $rose(firstEn)) |=> (firstEn || dstRst));

endmodule

// File: rtl/enable_chain_dp.sv
module enable_chain_dp
  import enable_chain_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              dstClk,
  input  logic              dstRst,
  input  stageStrobes_t     strobes,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] stage1Q,
  output logic [DATA_W-1:0] stage2Q
);

  always_ff @(posedge dstClk) begin
    if (dstRst)                 stage1Q <= '0;
    else if (strobes.loadFirst) stage1Q <= srcData;
  end

  always_ff @(posedge dstClk) begin
    if (dstRst)                  stage2Q <= '0;
    else if (strobes.loadSecond) stage2Q <= stage1Q;
  end

  // R4
  no_gap_chk: assert property (@(posedge dstClk) disable iff (dstRst)
    $fell(strobes.loadFirst) |-> strobes.loadSecond);

  // R3
  stage2_follow_chk: assert property (@(posedge dstClk) disable iff (dstRst)
    $rose(strobes.loadFirst) |=> (strobes.loadSecond || dstRst));

  // R5
  stage1_hold_chk: assert property (@(posedge dstClk) disable iff (dstRst)
    (!$past(dstRst) && !$past(strobes.loadFirst)) |-> $stable(stage1Q));

  // R6
  stage2_hold_chk: assert property (@(posedge dstClk) disable iff (dstRst)
    (!$past(dstRst) && !$past(strobes.loadSecond)) |-> $stable(stage2Q));

endmodule

// File: rtl/enable_chain_cdc.sv
module enable_chain_cdc
  import enable_chain_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRst,
  input  logic              srcEn,
  input  logic [DATA_W-1:0] srcData,
  input  logic              dstClk,
  input  logic              dstRst,
  output logic              stage1En,
  output logic              stage2En,
  output logic [DATA_W-1:0] stage1Data,
  output logic [DATA_W-1:0] stage2Data
);

  logic          srcEnQ;
  stageStrobes_t strobes;

  enable_chain_src u_src (
    .srcClk (srcClk),
    .srcRst (srcRst),
    .srcEn  (srcEn),
    .srcEnQ (srcEnQ)
  );

  enable_chain_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .dstClk  (dstClk),
    .dstRst  (dstRst),
    .srcEnQ  (srcEnQ),
    .strobes (strobes)
  );

  enable_chain_dp #(.DATA_W(DATA_W)) u_dp (
    .dstClk  (dstClk),
    .dstRst  (dstRst),
    .strobes (strobes),
    .srcData (srcData),
    .stage1Q (stage1Data),
    .stage2Q (stage2Data)
  );

  assign stage1En = strobes.loadFirst;
  assign stage2En = strobes.loadSecond;

endmodule

// File: tb/sim_enable_chain_cdc.sv
`timescale 1ns/1ps
module sim_enable_chain_cdc;
  localparam int DATA_W = 16;
  localparam int SYNC   = 2;

  logic srcClk = 1'b0, dstClk = 1'b0;
  logic srcRst = 1'b1, dstRst = 1'b1, srcEn = 1'b0;
  logic [DATA_W-1:0] srcData = '0;
  logic stage1En, stage2En;
  logic [DATA_W-1:0] stage1Data, stage2Data;

  real srcHalf = 6.5;
  int checks = 0, failures = 0, pulses = 0, rises = 0, dstCycles = 0;

  enable_chain_cdc #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) u0 (
    .srcClk(srcClk), .srcRst(srcRst), .srcEn(srcEn), .srcData(srcData),
    .dstClk(dstClk), .dstRst(dstRst), .stage1En(stage1En), .stage2En(stage2En),
    .stage1Data(stage1Data), .stage2Data(stage2Data));

  always #4 dstClk = ~dstClk;          // 125 MHz
  always #(srcHalf) srcClk = ~srcClk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, compared each destination cycle
  logic pS1En = 0, pS2En = 0, pRst = 1;
  logic [DATA_W-1:0] pD1 = '0, pD2 = '0;
  bit mValid = 0;

  always @(negedge dstClk) begin
    dstCycles++;
    if (mValid) begin
      if (pRst) begin
        check({stage1En, stage2En, stage1Data, stage2Data} == '0, "R1 reset clears",
              {stage1En, stage2En, stage1Data[13:0], stage2Data}, 0);
      end else begin
        check(stage2En == pS1En, "R3 stage2En", stage2En, pS1En);
        check(stage1Data == (pS1En ? srcData : pD1), "R5 stage1Data", stage1Data,
              pS1En ? srcData : pD1);
        check(stage2Data == (pS2En ? pD1 : pD2), "R6 stage2Data", stage2Data,
              pS2En ? pD1 : pD2);
        if (pS1En && !stage1En) check(stage2En, "R4 no gap", stage2En, 1);
        if (stage1En && !pS1En) rises++;
      end
    end
    pS1En = stage1En; pS2En = stage2En; pD1 = stage1Data; pD2 = stage2Data;
    pRst = dstRst; mValid = 1;
  end

  always @(posedge dstClk) begin
    if (dstCycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", dstCycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int maxLat();
    return SYNC + int'($ceil(2.0 * srcHalf / 8.0)) + 2;
  endfunction

  task automatic pulse(input logic [DATA_W-1:0] d, input int gap);
    int n;
    while (stage1En) @(negedge dstClk);
    #(0.7 * gap);
    @(negedge srcClk); #0.3;
    srcData = d; srcEn = 1'b1; pulses++;
    n = 0;
    do begin @(negedge dstClk); n++; end while (!stage1En && n < 100);
    check(n >= SYNC && n <= maxLat(), "R2 latency", n, maxLat());
    #30;
    @(negedge srcClk); #0.3;
    srcEn = 1'b0;
    repeat (gap % 4) @(negedge dstClk);
  endtask

  initial begin
    int n;
    repeat (5) @(negedge dstClk);
    check({stage1En, stage2En, stage1Data, stage2Data} == '0, "R1 initial",
          {stage1En, stage2En, stage1Data[13:0], stage2Data}, 0);
    @(posedge dstClk); #2 dstRst = 1'b0;
    @(negedge srcClk); #0.3 srcRst = 1'b0;
    repeat (3) @(negedge dstClk);

    for (int i = 0; i < 20; i++) pulse(16'h1000 + 16'(i * 37), i);
    srcHalf = 3.7;
    for (int i = 0; i < 20; i++) pulse(16'h5000 + 16'(i * 91), i + 3);
    srcHalf = 17.0;
    for (int i = 0; i < 10; i++) pulse(16'h9000 + 16'(i * 13), i);
    srcHalf = 5.3;

    // R8: source reset overrides a held source enable
    while (stage1En) @(negedge dstClk);
    @(negedge srcClk); #0.3 srcData = 16'h7E7E; srcEn = 1'b1; pulses++;
    while (!stage1En) @(negedge dstClk);
    repeat (3) @(negedge dstClk);
    @(negedge srcClk); #0.3 srcRst = 1'b1;
    n = 0;
    do begin @(negedge dstClk); n++; end while (stage1En && n < 100);
    check(n <= maxLat(), "R8 reset latency", n, maxLat());
    for (int i = 0; i < 6; i++) begin
      @(negedge dstClk);
      check(!stage1En, "R8 held low", stage1En, 0);
    end
    @(negedge srcClk); #0.3 srcEn = 1'b0;
    @(negedge srcClk); #0.3 srcRst = 1'b0;
    repeat (6) @(negedge dstClk);

    // R1: destination reset mid-run wipes loaded data
    pulse(16'hA5C3, 2);
    while (stage2Data != 16'hA5C3 && dstCycles < 140000) @(negedge dstClk);
    while (stage1En || stage2En) @(negedge dstClk);
    @(posedge dstClk); #2 dstRst = 1'b1;
    @(posedge dstClk); #2 dstRst = 1'b1;
    @(posedge dstClk); #2 dstRst = 1'b0;
    @(negedge dstClk);
    check(stage2Data == 0 && stage1Data == 0, "R1 mid-run reset", stage2Data, 0);

    pulse(16'h3C3C, 1);
    while (stage1En || stage2En) @(negedge dstClk);
    repeat (4) @(negedge dstClk);
    check(rises == pulses, "R7 one run per pulse", rises, pulses);
    check(stage2Data == 16'h3C3C, "R6 final value", stage2Data, 16'h3C3C);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule